// File: doc/BRIEF.md
# Two-Wire Serial Slave for a 512-Byte Memory

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that gives a bus master access to a 512-byte internal memory array. The array has no write latency, so the slave never reports a busy state. Every data byte is committed in the same system-clock cycle in which its last bit arrives. The master addresses the device with one byte. The top six bits of that byte must equal a fixed select pattern. The next bit supplies the ninth (top) memory address bit, and the lowest bit chooses read (1) or write (0).

A write transaction follows the device byte with one word-address byte, which loads the low eight bits of an internal address latch. Any number of data bytes can follow. A read transaction has no word-address phase: it streams bytes from the current latch value, which is the location after the previous access. The latch steps by one after each byte and wraps from 0x1FF to 0x000. A random read is therefore a write of the word address, a repeated start, and then a read.

When the write-protect input is high, data bytes are neither stored nor acknowledged, and the latch holds its value. Both bus lines are resynchronised to the system clock. SDA is driven through an open-drain enable that pulls the line low when set.

Top module: `serial_byte_mem`

## Requirements
- R1: A high-to-low SDA transition while SCL is high (start) puts the slave into the device-byte phase from any state, and no SDA drive follows it. A low-to-high SDA transition while SCL is high (stop) releases SDA and returns the slave to idle.
- R2: A device byte whose bits [7:2] equal 6'b101000 is acknowledged, even while write protect is high. Any other value is not acknowledged, and the slave stays off the bus until the next start.
- R3: Bit 1 of the device byte is loaded into address bit 8, and bit 0 selects the operation: 0 for write, 1 for read.
- R4: In a write, the byte after the device byte sets address bits [7:0]. Each data byte after it is acknowledged and stored at the latch address. All bytes are shifted MSB first.
- R5: A read sends bytes MSB first from the latch address, with no word-address phase. It sends the next byte after each master acknowledge. After a master not-acknowledge it releases SDA and stops driving.
- R6: The latch advances by one after every transferred data byte and wraps from 0x1FF to 0x000, for both reads and writes.
- R7: While write protect is high, data bytes are not stored, their acknowledge slot is left released, and the latch does not advance.
- R8: A stop or start that arrives before the eighth bit of a data byte leaves memory unchanged.
- R9: A repeated start keeps the address latch, so a read after it resumes at the latch value (with bit 8 taken from the new device byte).
- R10: Reset clears the latch to 0x000 and releases SDA. Memory contents survive reset.
- R11: The slave changes the SDA drive only while SCL is low, so the line is steady during every SCL high phase of a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used for sampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Level sensed on the serial data line |
| wp_i | input | 1 | Write protect; high blocks stores to the array |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A corrupted address latch shows up as a wrong byte on the very next read. It also shows up one byte late in a wrap or resume check, because the read that follows a write or a not-acknowledge starts from the latch value and does not reload it. A wrong phase or bit count shows at the ports within one byte time as a missing or misplaced acknowledge, or as SDA moving during SCL high. A write that should have been suppressed stays hidden until the location is read back, so every write-side case is paired with a read of both the target location and the location next to it.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } sbm_state_e;

    // Synchronised bus view shared by the controller and the checker.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } sbm_bus_t;

    function automatic logic is_rx_state(input sbm_state_e s);
        return (s == ST_DEV) || (s == ST_WADDR) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/sbm_bus_sync.sv
module sbm_bus_sync
    import sbm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_lvl,
    output sbm_bus_t bus
);

    localparam int CUR  = STAGES - 1;
    localparam int PREV = STAGES;

    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_lvl      = scl_p[CUR];
        bus.sda      = sda_p[CUR];
        bus.scl_rise = scl_p[CUR] & ~scl_p[PREV];
        bus.scl_fall = ~scl_p[CUR] & scl_p[PREV];
        bus.start    = scl_p[CUR] & scl_p[PREV] & sda_p[PREV] & ~sda_p[CUR];
        bus.stop     = scl_p[CUR] & scl_p[PREV] & ~sda_p[PREV] & sda_p[CUR];
    end

endmodule

// File: rtl/sbm_mem_array.sv
module sbm_mem_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
#(
    parameter int         ADDR_W = 9,
    parameter logic [6:0] DEV_ID = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst,
    input  sbm_bus_t          bus,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output sbm_state_e        state
);

    localparam int PAGE_W = ADDR_W - BYTE_W;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    sbm_state_e           st_q;
    sbm_state_e           after_ack_q;
    logic [BIT_CNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0]    sh_q;
    logic                 ack_drv_q;
    logic                 ack_on_q;
    logic                 m_ack_q;
    logic [ADDR_W-1:0]    addr_q;

    logic [BYTE_W-1:0]    rx_byte;
    logic [ADDR_W-1:0]    addr_inc;
    logic                 byte_done;
    logic                 sel_hit;

    assign rx_byte   = {sh_q[BYTE_W-2:0], bus.sda};
    assign addr_inc  = addr_q + ADDR_W'(1);
    assign byte_done = bus.scl_rise && (cnt_q == LAST_BIT);
    assign sel_hit   = (rx_byte[BYTE_W-1:PAGE_W+1] == DEV_ID[6:PAGE_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            after_ack_q <= ST_IDLE;
            cnt_q       <= '0;
            sh_q        <= '0;
            ack_drv_q   <= 1'b0;
            ack_on_q    <= 1'b0;
            m_ack_q     <= 1'b0;
            addr_q      <= '0;
        end else if (bus.start) begin
            st_q     <= ST_DEV;
            cnt_q    <= '0;
            ack_on_q <= 1'b0;
        end else if (bus.stop) begin
            st_q     <= ST_IDLE;
            ack_on_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (bus.scl_rise) begin
                        sh_q  <= rx_byte;
                        cnt_q <= cnt_q + BIT_CNT_W'(1);
                    end
                    if (byte_done) begin
                        if (st_q == ST_DEV) begin
                            if (sel_hit) begin
                                addr_q[ADDR_W-1:BYTE_W] <= rx_byte[PAGE_W:1];
                                ack_drv_q   <= 1'b1;
                                after_ack_q <= rx_byte[0] ? ST_RDATA : ST_WADDR;
                                st_q        <= ST_ACK;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end else if (st_q == ST_WADDR) begin
                            addr_q[BYTE_W-1:0] <= rx_byte;
                            ack_drv_q   <= 1'b1;
                            after_ack_q <= ST_WDATA;
                            st_q        <= ST_ACK;
                        end else begin
                            ack_drv_q   <= ~wp_i;
                            after_ack_q <= ST_WDATA;
                            st_q        <= ST_ACK;
                            if (!wp_i) begin
                                addr_q <= addr_inc;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (bus.scl_fall) begin
                        if (!ack_on_q) begin
                            ack_on_q <= 1'b1;
                        end else begin
                            ack_on_q <= 1'b0;
                            cnt_q    <= '0;
                            st_q     <= after_ack_q;
                            if (after_ack_q == ST_RDATA) begin
                                sh_q <= rd_data;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (bus.scl_fall) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                        cnt_q <= cnt_q + BIT_CNT_W'(1);
                        if (cnt_q == LAST_BIT) begin
                            addr_q <= addr_inc;
                            st_q   <= ST_RACK;
                        end
                    end
                end
                ST_RACK: begin
                    if (bus.scl_rise) begin
                        m_ack_q <= ~bus.sda;
                    end
                    if (bus.scl_fall) begin
                        if (m_ack_q) begin
                            sh_q  <= rd_data;
                            cnt_q <= '0;
                            st_q  <= ST_RDATA;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    st_q <= st_q;
                end
            endcase
        end
    end

    assign mem_we  = (st_q == ST_WDATA) && byte_done && !wp_i;
    assign wr_data = rx_byte;
    assign addr    = addr_q;
    assign state   = st_q;
    assign sda_oe  = ((st_q == ST_ACK) && ack_on_q && ack_drv_q) ||
                     ((st_q == ST_RDATA) && !sh_q[BYTE_W-1]);

endmodule

// File: rtl/serial_byte_mem.sv
module serial_byte_mem
    import sbm_pkg::*;
#(
    parameter int         ADDR_W      = 9,
    parameter logic [6:0] DEV_ID      = 7'b1010000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    sbm_bus_t          bus_w;
    logic              scl_lvl_w;
    logic [ADDR_W-1:0] addr_w;
    logic              mem_we_w;
    logic [BYTE_W-1:0] wr_data_w;
    logic [BYTE_W-1:0] rd_data_w;
    sbm_state_e        ctrl_state;

    sbm_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl_w),
        .bus     (bus_w)
    );

    sbm_ctrl #(
        .ADDR_W (ADDR_W),
        .DEV_ID (DEV_ID)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus_w),
        .wp_i    (wp_i),
        .rd_data (rd_data_w),
        .addr    (addr_w),
        .mem_we  (mem_we_w),
        .wr_data (wr_data_w),
        .sda_oe  (sda_oe),
        .state   (ctrl_state)
    );

    sbm_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we_w),
        .waddr (addr_w),
        .wdata (wr_data_w),
        .raddr (addr_w),
        .rdata (rd_data_w)
    );

endmodule

// File: rtl/sbm_chk.sv
module sbm_chk
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              sda_oe,
    input logic              wp,
    input logic              start_evt,
    input logic              stop_evt,
    input sbm_state_e        state,
    input logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_next;
    assign addr_next = addr + ADDR_W'(1);

    // R11
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R7
    wp_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA && wp) |=> $stable(addr));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA || state == ST_RDATA) |=>
            (addr == $past(addr) || addr == $past(addr_next)));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (!sda_oe && state == ST_IDLE));

    // R1
    start_dev_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (state == ST_DEV && !sda_oe));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (addr == '0 && !sda_oe));

endmodule

bind serial_byte_mem sbm_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl_w),
    .sda_oe    (sda_oe),
    .wp        (wp_i),
    .start_evt (bus_w.start),
    .stop_evt  (bus_w.stop),
    .state     (ctrl_state),
    .addr      (addr_w)
);

// File: tb/tb_serial_byte_mem.sv
module tb_serial_byte_mem;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst;
    logic scl_m;
    logic sda_m;
    logic wp;
    wire  sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    serial_byte_mem dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    localparam logic [5:0] SEL = 6'b101000;
    localparam int NV = 8;
    localparam logic [16:0] VEC [NV] = '{
        {9'h005, 8'h3C}, {9'h105, 8'hC3}, {9'h000, 8'hA5}, {9'h0FF, 8'h5A},
        {9'h100, 8'h81}, {9'h1FF, 8'h7E}, {9'h080, 8'h01}, {9'h17F, 8'hFE}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic page, input logic rd);
        return {SEL, page, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; hold(8);
        scl_m = 1'b1; hold(8);
        sda_m = 1'b0; hold(8);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(8);
        scl_m = 1'b1; hold(8);
        sda_m = 1'b1; hold(8);
    endtask

    task automatic send_bit(input logic v);
        sda_m = v; hold(8);
        scl_m = 1'b1; hold(8);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(8);
        scl_m = 1'b1; hold(4);
        ack = (sda_bus == 1'b0);
        hold(4);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b,
                             output logic steady);
        logic s0, s1;
        steady = 1'b1;
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hold(8);
            scl_m = 1'b1; hold(2);
            s0 = sda_bus; hold(5);
            s1 = sda_bus;
            if (s0 !== s1) steady = 1'b0;
            b = {b[6:0], s1};
            hold(1);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hold(8);
        scl_m = 1'b1; hold(8);
        scl_m = 1'b0; hold(2);
        sda_m = 1'b1;
    endtask

    task automatic write_one(input logic [8:0] a, input logic [7:0] d, input string req);
        logic a0, a1, a2;
        bus_start();
        send_byte(dev(a[8], 1'b0), a0);
        send_byte(a[7:0], a1);
        send_byte(d, a2);
        bus_stop();
        check(req, "write acks", {13'd0, a0, a1, a2}, 16'h0007);
    endtask

    task automatic random_read(input logic [8:0] a, output logic [7:0] d);
        logic ak, st;
        bus_start();
        send_byte(dev(a[8], 1'b0), ak);
        send_byte(a[7:0], ak);
        bus_start();
        send_byte(dev(a[8], 1'b1), ak);
        recv_byte(1'b0, d, st);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, d2, d3;
        logic ak, ak2, st;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
        hold(6);
        rst = 1'b0;
        hold(4);
        check("R10", "sda released after reset", {15'd0, sda_oe}, 16'd0);

        // R4: table-driven single-byte writes
        for (int i = 0; i < NV; i++) write_one(VEC[i][16:8], VEC[i][7:0], "R4");
        // R3 / R9: random reads across both pages via repeated start
        for (int i = 0; i < NV; i++) begin
            random_read(VEC[i][16:8], d);
            check("R9", "random read", {8'd0, d}, {8'd0, VEC[i][7:0]});
        end

        // R10: reset clears latch, memory kept (0x000 holds A5)
        rst = 1'b1; hold(3); rst = 1'b0; hold(4);
        bus_start();
        send_byte(dev(1'b0, 1'b1), ak);
        recv_byte(1'b0, d, st);
        bus_stop();
        check("R10", "read after reset at 0x000", {8'd0, d}, 16'h00A5);

        // R2: select mismatch ignored until next start; R1 start recovers
        bus_start();
        send_byte(8'hB0, ak);
        check("R2", "mismatched select ack", {15'd0, ak}, 16'd0);
        send_byte(8'h00, ak);
        check("R2", "byte after mismatch ack", {15'd0, ak}, 16'd0);
        bus_start();
        send_byte(dev(1'b0, 1'b1), ak);
        check("R1", "device ack after new start", {15'd0, ak}, 16'd1);
        recv_byte(1'b0, d, st);
        bus_stop();

        // R6: multi-byte write across 0x1FF -> 0x000, then read it back
        write_one(9'h001, 8'h44, "R4");
        bus_start();
        send_byte(dev(1'b1, 1'b0), ak);
        send_byte(8'hFE, ak);
        send_byte(8'h11, ak);
        send_byte(8'h22, ak2);
        send_byte(8'h33, ak);
        bus_stop();
        check("R4", "burst acks", {14'd0, ak, ak2}, 16'h0003);
        bus_start();
        send_byte(dev(1'b1, 1'b0), ak);
        send_byte(8'hFE, ak);
        bus_start();
        send_byte(dev(1'b1, 1'b1), ak);
        recv_byte(1'b1, d, st);
        check("R11", "SDA steady while SCL high", {15'd0, st}, 16'd1);
        recv_byte(1'b1, d2, st);
        recv_byte(1'b0, d3, st);
        check("R6", "read 0x1FE", {8'd0, d}, 16'h0011);
        check("R6", "read 0x1FF", {8'd0, d2}, 16'h0022);
        check("R6", "read wrapped 0x000", {8'd0, d3}, 16'h0033);
        hold(10);
        check("R5", "released after nack", {15'd0, sda_oe}, 16'd0);
        bus_stop();
        // R5: read resumes at latch (0x001) with no word address
        bus_start();
        send_byte(dev(1'b0, 1'b1), ak);
        recv_byte(1'b0, d, st);
        bus_stop();
        check("R5", "resume read at 0x001", {8'd0, d}, 16'h0044);

        // R7: write protect
        write_one(9'h010, 8'h99, "R4");
        write_one(9'h011, 8'h77, "R4");
        wp = 1'b1;
        bus_start();
        send_byte(dev(1'b0, 1'b0), ak);
        check("R2", "device ack under protect", {15'd0, ak}, 16'd1);
        send_byte(8'h10, ak);
        send_byte(8'h12, ak);
        check("R7", "protected data ack", {15'd0, ak}, 16'd0);
        send_byte(8'h34, ak);
        bus_stop();
        wp = 1'b0;
        bus_start();
        send_byte(dev(1'b0, 1'b1), ak);
        recv_byte(1'b1, d, st);
        recv_byte(1'b0, d2, st);
        bus_stop();
        check("R7", "latch held and 0x010 kept", {8'd0, d}, 16'h0099);
        check("R7", "0x011 kept", {8'd0, d2}, 16'h0077);

        // R8: stop before eighth bit aborts the byte
        write_one(9'h020, 8'h6B, "R4");
        bus_start();
        send_byte(dev(1'b0, 1'b0), ak);
        send_byte(8'h20, ak);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        random_read(9'h020, d);
        check("R8", "stop abort keeps 0x020", {8'd0, d}, 16'h006B);
        // R8 / R9: start before eighth bit aborts; latch kept for read
        bus_start();
        send_byte(dev(1'b0, 1'b0), ak);
        send_byte(8'h20, ak);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte(dev(1'b0, 1'b1), ak);
        recv_byte(1'b0, d, st);
        bus_stop();
        check("R8", "start abort keeps 0x020", {8'd0, d}, 16'h006B);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule